// File: doc/BRIEF.md
# Sticky Error Register with Transfer Handshake

This block collects single-cycle fault strobes from a signal-processing datapath into a set of sticky error flags that a processor reads through a 16-bit register port. A read both returns the flags and clears them in the same access. An event that lands in the very cycle of the clearing read is not lost: it is latched again after the clear and appears on the next read.

The block also guards processor data transfers against RF pulses. Software writes the register at the start of a transfer, with any data, to arm a token. It reads the register as the final step, which disarms the token and shows whether an RF pulse started during the transfer. A rising edge of the RF pulse input while the token is armed sets the handshake error flag.

Top module: `err_latch_hs`

## Requirements
- R1: After reset all error flags are clear, the token is disarmed and `bus_rdata_o` is 0.
- R2: Flag positions: bit 0 is `ovf_i[0]` (channel D overflow), bit 1 is `ovf_i[1]` (C), bit 2 is `ovf_i[2]` (B), bit 3 is `ovf_i[3]` (A), bit 4 is clock missing, bit 5 is trigger skipped, bit 6 is sync missing, bit 7 is sync error, bit 8 is handshake error and bit 9 is PLL unlocked. Bit 8 has no direct input.
- R3: A read (`bus_sel_i` and `bus_rd_i` high at a rising edge) loads `bus_rdata_o` at that edge with the flags held before it. The value stays until the next read. Bits 31 down to 10 are always 0.
- R4: The read clears every flag at the same edge. A strobe that is high in the read cycle leaves its flag set after the clear.
- R5: A flag stays set across any number of cycles until a read clears it. Events on different bits accumulate by OR.
- R6: A write (`bus_sel_i` and `bus_wr_i` high) arms the token. The write data is ignored, and the write changes no flag.
- R7: A rising edge of `rf_pulse_i` while the token is armed sets bit 8. A level held high does not count again.
- R8: A read disarms the token, so later RF edges set no flag. A write and a read in the same cycle leave the token armed.
- R9: `bus_rd_i` or `bus_wr_i` with `bus_sel_i` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_i | input | 4 | Channel overflow strobes, index 0 = channel D, index 3 = channel A |
| clk_miss_i | input | 1 | Clock missing strobe |
| trig_skip_i | input | 1 | External trigger skipped strobe |
| sync_miss_i | input | 1 | Sync missing strobe |
| sync_err_i | input | 1 | Sync error strobe |
| pll_unlock_i | input | 1 | PLL unlocked strobe |
| rf_pulse_i | input | 1 | RF pulse level; its rising edge marks the start of a pulse |
| bus_sel_i | input | 1 | Register selected by the bus decoder |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | REG_W | Write data (ignored) |
| bus_rdata_o | output | BUS_W | Read data, zero-extended |

## Verification
An event strobe or an RF edge sampled at one rising edge is latched at that edge. A read strobe sampled at edge N moves the flags onto `bus_rdata_o` at edge N and clears them. The bench drives every stimulus on the falling edge and removes it on the next falling edge. It then samples `bus_rdata_o` at that second falling edge, half a cycle after the edge that loaded it. Tests of ignored strobes and of token state are read back through a later read of the register, so any stray change shows up at the port.

// File: rtl/errlatch_pkg.sv
package errlatch_pkg;
    localparam int ERR_W  = 10;
    localparam int HS_BIT = 8;

    typedef logic [ERR_W-1:0] err_vec_t;

    typedef struct packed {
        err_vec_t snap;
    } rd_state_t;

    typedef struct packed {
        logic token;
    } hs_state_t;
endpackage

// File: rtl/rf_edge.sv
module rf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
        rise_o = sig_i & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/err_sticky.sv
module err_sticky #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] bit_d, bit_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            bit_d[i] = set_i[i] | (bit_q[i] & ~clr_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bit_q <= '0;
        else        bit_q <= bit_d;
    end

    assign q_o = bit_q;
endmodule

// File: rtl/hs_token.sv
module hs_token
    import errlatch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic rd_i,
    input  logic rise_i,
    output logic token_o,
    output logic hs_err_o
);
    hs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i)      st_d.token = 1'b1;
        else if (rd_i) st_d.token = 1'b0;
        hs_err_o = rise_i & st_q.token;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign token_o = st_q.token;
endmodule

// File: rtl/err_latch_hs.sv
module err_latch_hs
    import errlatch_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ovf_i,
    input  logic             clk_miss_i,
    input  logic             trig_skip_i,
    input  logic             sync_miss_i,
    input  logic             sync_err_i,
    input  logic             pll_unlock_i,
    input  logic             rf_pulse_i,
    input  logic             bus_sel_i,
    input  logic             bus_rd_i,
    input  logic             bus_wr_i,
    input  logic [REG_W-1:0] bus_wdata_i,
    output logic [BUS_W-1:0] bus_rdata_o
);
    localparam int PAD_W = BUS_W - ERR_W;

    logic      rd_acc, wr_acc;
    logic      rf_rise, hs_err, token_q;
    err_vec_t  set_vec, err_q;
    rd_state_t rs_d, rs_q;
    logic      unused_wdata;

    assign unused_wdata = ^bus_wdata_i;
    assign rd_acc = bus_sel_i & bus_rd_i;
    assign wr_acc = bus_sel_i & bus_wr_i;

    rf_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (rf_pulse_i),
        .rise_o (rf_rise)
    );

    hs_token u_token (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_acc),
        .rd_i     (rd_acc),
        .rise_i   (rf_rise),
        .token_o  (token_q),
        .hs_err_o (hs_err)
    );

    assign set_vec = {pll_unlock_i, hs_err, sync_err_i, sync_miss_i,
                      trig_skip_i, clk_miss_i, ovf_i};

    err_sticky #(.W(ERR_W)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (rd_acc),
        .q_o   (err_q)
    );

    always_comb begin
        rs_d = rs_q;
        if (rd_acc) rs_d.snap = err_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign bus_rdata_o = {{PAD_W{1'b0}}, rs_q.snap};
endmodule

// File: rtl/err_latch_hs_chk.sv
module err_latch_hs_chk
    import errlatch_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd,
    input logic             wr,
    input logic             rise,
    input err_vec_t         set_vec,
    input err_vec_t         err_q,
    input logic             token_q,
    input logic [BUS_W-1:0] rdata
);
    a_r3_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rdata[ERR_W-1:0] == $past(err_q));

    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

    a_r4_clear_keep_new: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> err_q == $past(set_vec));

    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> (err_q & $past(err_q)) == $past(err_q));

    a_r6_arm: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> token_q);

    a_r8_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr) |=> !token_q);

    a_r7_hs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (token_q && rise) |=> err_q[HS_BIT]);
endmodule

bind err_latch_hs err_latch_hs_chk #(.BUS_W(BUS_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (rd_acc),
    .wr      (wr_acc),
    .rise    (rf_rise),
    .set_vec (set_vec),
    .err_q   (err_q),
    .token_q (token_q),
    .rdata   (bus_rdata_o)
);

// File: tb/err_latch_hs_bench.sv
module err_latch_hs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ovf_i = '0;
    logic        clk_miss_i = 0, trig_skip_i = 0, sync_miss_i = 0;
    logic        sync_err_i = 0, pll_unlock_i = 0, rf_pulse_i = 0;
    logic        bus_sel_i = 0, bus_rd_i = 0, bus_wr_i = 0;
    logic [15:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    err_latch_hs u_err_latch_hs (.*);

    localparam int NV = 6;
    localparam logic [9:0]  EV  [NV] = '{10'h001, 10'h008, 10'h030,
                                         10'h2C0, 10'h100, 10'h3FF};
    localparam logic [15:0] EXP [NV] = '{16'h0001, 16'h0008, 16'h0030,
                                         16'h02C0, 16'h0000, 16'h02FF};

    task automatic check(input logic [31:0] got, input logic [31:0] exp,
                         input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive_ev(input logic [9:0] v);
        ovf_i        = v[3:0];
        clk_miss_i   = v[4];
        trig_skip_i  = v[5];
        sync_miss_i  = v[6];
        sync_err_i   = v[7];
        pll_unlock_i = v[9];
    endtask

    task automatic fire(input logic [9:0] v);
        @(negedge clk); drive_ev(v);
        @(negedge clk); drive_ev('0);
    endtask

    task automatic read_chk(input logic [31:0] exp, input string tag);
        @(negedge clk); bus_sel_i = 1; bus_rd_i = 1;
        @(negedge clk); bus_sel_i = 0; bus_rd_i = 0;
        check(bus_rdata_o, exp, tag);
    endtask

    task automatic wr_reg(input logic [15:0] d);
        @(negedge clk); bus_sel_i = 1; bus_wr_i = 1; bus_wdata_i = d;
        @(negedge clk); bus_sel_i = 0; bus_wr_i = 0; bus_wdata_i = '0;
    endtask

    task automatic rf_pulse();
        @(negedge clk); rf_pulse_i = 1;
        @(negedge clk); rf_pulse_i = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(bus_rdata_o, 32'h0, "R1 rdata after reset");
        read_chk(32'h0, "R1 flags clear after reset");
        rf_pulse();
        read_chk(32'h0, "R1 token disarmed after reset");

        // R2 R3: table of single events and the read value they produce
        for (int i = 0; i < NV; i++) begin
            fire(EV[i]);
            read_chk({16'h0, EXP[i]}, $sformatf("R2 vector %0d", i));
        end

        // R5: flags accumulate and persist
        fire(10'h010);
        repeat (5) @(negedge clk);
        fire(10'h001);
        read_chk(32'h11, "R5 accumulate");
        read_chk(32'h0, "R4 cleared by read");

        // R4: event in the read cycle survives the clear
        fire(10'h008);
        @(negedge clk); bus_sel_i = 1; bus_rd_i = 1; sync_err_i = 1;
        @(negedge clk); bus_sel_i = 0; bus_rd_i = 0; sync_err_i = 0;
        check(bus_rdata_o, 32'h8, "R4 read returns old value");
        read_chk(32'h80, "R4 same-cycle event kept");

        // R3: value held between reads
        repeat (4) @(negedge clk);
        check(bus_rdata_o, 32'h80, "R3 rdata held");

        // R6: write ignores data and leaves flags unchanged
        fire(10'h010);
        wr_reg(16'hFFFF);
        read_chk(32'h10, "R6 write changes no flag");

        // R6 R7: arm, pulse, flag
        wr_reg(16'h0000);
        rf_pulse();
        read_chk(32'h100, "R7 pulse while armed");

        // R8: after read, pulse sets nothing
        rf_pulse();
        read_chk(32'h0, "R8 disarmed after read");

        // R7: held level does not retrigger
        wr_reg(16'h1234);
        @(negedge clk); rf_pulse_i = 1;
        repeat (3) @(negedge clk);
        read_chk(32'h100, "R7 first edge flagged");
        wr_reg(16'h0);
        repeat (3) @(negedge clk);
        read_chk(32'h0, "R7 held level no new edge");
        @(negedge clk); rf_pulse_i = 0;
        @(negedge clk);

        // R9: strobes without select have no effect
        fire(10'h020);
        @(negedge clk); bus_rd_i = 1;
        @(negedge clk); bus_rd_i = 0;
        check(bus_rdata_o, 32'h0, "R9 unselected read leaves rdata");
        read_chk(32'h20, "R9 unselected read did not clear");
        @(negedge clk); bus_wr_i = 1;
        @(negedge clk); bus_wr_i = 0;
        rf_pulse();
        read_chk(32'h0, "R9 unselected write did not arm");

        // R8: write and read together leave token armed
        @(negedge clk); bus_sel_i = 1; bus_rd_i = 1; bus_wr_i = 1;
        @(negedge clk); bus_sel_i = 0; bus_rd_i = 0; bus_wr_i = 0;
        rf_pulse();
        read_chk(32'h100, "R8 write wins over read");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule